// File: doc/BRIEF.md
# SPI Ferroelectric RAM Target

This block is the target side of an SPI mode-0 link. It behaves like a small byte-addressable RAM that is reached through a command set of the kind serial flash uses. Each chip-select frame starts with an opcode byte. Depending on the opcode, the frame then carries address bytes, data bytes or nothing. There are no busy or erase states: data is written at the rate the bus delivers it, and the status register never shows a write in progress.

The serial lines are oversampled by a system clock. SCLK, CS_n and MOSI pass through a two-stage synchronizer, and SCLK edges are detected from the synchronized copy. MISO leaves the block with an output-enable flag, so the pad can be tri-stated whenever the target has nothing to say.

A parameter selects two or three address bytes, sent most significant byte first. Another parameter decides whether the identification command answers or leaves MISO undriven. The storage is an internal register array whose depth is a power of two.

Top module: `fram_spi_target`

## Requirements
- R1: After reset, miso_oe is 0, and the status byte read with opcode 0x05 is 0x00.
- R2: Opcode 0x06 sets the write-enable latch, which reads as status bit 1. Opcode 0x04 clears it.
- R3: Opcode 0x05 drives the status byte on MISO, MSB first, starting with the byte after the opcode. The byte repeats while CS_n stays low. Status bits 5, 4 and 0 always read 0, so no busy flag is ever reported.
- R4: Opcode 0x01 with the latch set stores the next byte into status bits 7, 6, 3 and 2. Without the latch, the frame leaves the status unchanged.
- R5: Opcode 0x03 takes ADDR_BYTES address bytes, MSB first. It then returns the stored byte at that address, and the following bytes at consecutive addresses, one per byte clocked.
- R6: Opcode 0x02 with the latch set takes ADDR_BYTES address bytes and then stores every following byte at consecutive addresses, back to back, with no wait between bytes.
- R7: Opcode 0x02 while the latch is clear stores nothing.
- R8: The rise of CS_n that ends an accepted 0x02 or 0x01 frame clears the latch.
- R9: The address counter wraps from DEPTH-1 to 0. Address bits above log2(DEPTH) are ignored.
- R10: With ID_ENABLE=1, opcode 0x9F returns 0xC2, then FAMILY_ID, then SUB_ID.
- R11: With ID_ENABLE=0, opcode 0x9F keeps miso_oe low for the whole frame.
- R12: A frame whose opcode is not listed above keeps miso_oe low and changes neither the latch nor the array until CS_n rises.
- R13: MOSI is sampled on rising SCLK, and MISO changes only after a falling SCLK edge.
- R14: miso_oe is low whenever CS_n is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the SPI lines |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| sclk | input | 1 | SPI clock, idle low (mode 0) |
| cs_n | input | 1 | Active-low chip select that bounds a frame |
| mosi | input | 1 | Serial data into the target |
| miso | output | 1 | Serial data out of the target |
| miso_oe | output | 1 | High while the target drives miso |

## Verification
Every SPI line reaches the logic two system clocks after it moves. The registered effect of a SCLK edge, such as a new MISO bit or a change in output enable, therefore appears on the third clock after the edge. The same latency applies to CS_n, so output enable drops and the latch clears three clocks after CS_n rises. The bench holds each SCLK level for six system clocks and samples MISO one clock before it raises SCLK. It samples MISO again just before the falling edge to confirm the value did not move on the rising edge. After a frame ends, the bench waits eight clocks before it reads output enable or starts a status read.

// File: rtl/fram_pkg.sv
package fram_pkg;
  localparam logic [7:0] OPC_WREN  = 8'h06;
  localparam logic [7:0] OPC_WRDI  = 8'h04;
  localparam logic [7:0] OPC_RDSR  = 8'h05;
  localparam logic [7:0] OPC_WRSR  = 8'h01;
  localparam logic [7:0] OPC_READ  = 8'h03;
  localparam logic [7:0] OPC_WRITE = 8'h02;
  localparam logic [7:0] OPC_RDID  = 8'h9F;
  localparam logic [7:0] ID_MAKER  = 8'hC2;
  // status bits software may set; bit 1 is the latch, the rest fixed zero
  localparam logic [7:0] SR_WMASK  = 8'hCC;

  typedef enum logic [2:0] {
    ST_OPC, ST_ADDR, ST_RDAT, ST_WDAT, ST_SRD, ST_SWR, ST_ID, ST_SKIP
  } fram_state_e;
endpackage

// File: rtl/fram_sync.sv
module fram_sync #(
  parameter int W = 3,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1, s2;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1 <= RST[i];
        s2 <= RST[i];
      end else begin
        s1 <= d[i];
        s2 <= s1;
      end
    end
    assign q[i] = s2;
  end
endmodule

// File: rtl/fram_rx.sv
module fram_rx (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       rise,
  input  logic       bit_in,
  output logic       byte_done,
  output logic [7:0] byte_val
);
  logic [2:0] cnt_q, cnt_d;
  logic [6:0] sh_q, sh_d;

  always_comb begin
    cnt_d     = cnt_q;
    sh_d      = sh_q;
    byte_done = rise & (cnt_q == 3'd7);
    byte_val  = {sh_q, bit_in};
    if (clr) begin
      cnt_d = 3'd0;
    end else if (rise) begin
      cnt_d = cnt_q + 3'd1;
      sh_d  = {sh_q[5:0], bit_in};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= 3'd0;
      sh_q  <= 7'd0;
    end else begin
      cnt_q <= cnt_d;
      sh_q  <= sh_d;
    end
  end
endmodule

// File: rtl/fram_mem.sv
module fram_mem #(
  parameter int DEPTH = 128,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/fram_spi_target.sv
module fram_spi_target
  import fram_pkg::*;
#(
  parameter int          ADDR_BYTES = 2,
  parameter int          DEPTH      = 128,
  parameter bit          ID_ENABLE  = 1'b1,
  parameter logic [7:0]  FAMILY_ID  = 8'h22,
  parameter logic [7:0]  SUB_ID     = 8'h01
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic cs_n,
  input  logic mosi,
  output logic miso,
  output logic miso_oe
);
  localparam int AW = $clog2(DEPTH);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_q;
  logic       rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_core_n = rst_q[1];

  // line synchronizer and edge detection
  logic [2:0] sync_q;
  logic       sclk_s, cs_s, mosi_s, sclk_d, cs_d;
  logic       rise, fall, cs_end;

  fram_sync #(.W(3), .RST(3'b010)) u_sync (
    .clk(clk), .rst_n(rst_core_n), .d({sclk, cs_n, mosi}), .q(sync_q)
  );
  assign {sclk_s, cs_s, mosi_s} = sync_q;

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      sclk_d <= 1'b0;
      cs_d   <= 1'b1;
    end else begin
      sclk_d <= sclk_s;
      cs_d   <= cs_s;
    end
  end
  assign rise   = ~cs_s &  sclk_s & ~sclk_d;
  assign fall   = ~cs_s & ~sclk_s &  sclk_d;
  assign cs_end =  cs_s & ~cs_d;

  // byte assembly
  logic       byte_done;
  logic [7:0] byte_val;
  fram_rx u_rx (
    .clk(clk), .rst_n(rst_core_n), .clr(cs_s), .rise(rise),
    .bit_in(mosi_s), .byte_done(byte_done), .byte_val(byte_val)
  );

  // frame state
  fram_state_e   state_q, state_d;
  logic [1:0]    acnt_q, acnt_d, idx_q, idx_d;
  logic [AW-1:0] ashift_q, ashift_d, ptr_q, ptr_d, addr_now, raddr;
  logic          wel_q, wel_d, wrf_q, wrf_d, iswr_q, iswr_d;
  logic          miso_q, miso_d, oe_q, oe_d, mem_we;
  logic [7:0]    sr_q, sr_d, tx_q, tx_d, rdata, status_val;

  assign addr_now   = (ashift_q << 8) | AW'(byte_val);
  assign status_val = (sr_q & SR_WMASK) | {6'd0, wel_q, 1'b0};
  assign raddr      = (state_q == ST_ADDR) ? addr_now : ptr_q;

  fram_mem #(.DEPTH(DEPTH)) u_mem (
    .clk(clk), .we(mem_we), .waddr(ptr_q), .wdata(byte_val),
    .raddr(raddr), .rdata(rdata)
  );

  always_comb begin
    state_d  = state_q;
    acnt_d   = acnt_q;
    idx_d    = idx_q;
    ashift_d = ashift_q;
    ptr_d    = ptr_q;
    wel_d    = wel_q;
    wrf_d    = wrf_q;
    iswr_d   = iswr_q;
    miso_d   = miso_q;
    oe_d     = oe_q;
    sr_d     = sr_q;
    tx_d     = tx_q;
    mem_we   = 1'b0;
    if (cs_s) begin
      state_d = ST_OPC;
      acnt_d  = 2'd0;
      idx_d   = 2'd0;
      oe_d    = 1'b0;
      wrf_d   = 1'b0;
      if (cs_end && wrf_q) wel_d = 1'b0;
    end else begin
      if (fall) begin
        miso_d = tx_q[7];
        tx_d   = {tx_q[6:0], 1'b0};
      end
      if (byte_done) begin
        unique case (state_q)
          ST_OPC: begin
            state_d = ST_SKIP;
            unique case (byte_val)
              OPC_WREN: wel_d = 1'b1;
              OPC_WRDI: wel_d = 1'b0;
              OPC_RDSR: begin
                state_d = ST_SRD;
                tx_d    = status_val;
                oe_d    = 1'b1;
              end
              OPC_WRSR: if (wel_q) begin
                state_d = ST_SWR;
                wrf_d   = 1'b1;
              end
              OPC_READ: begin
                state_d = ST_ADDR;
                iswr_d  = 1'b0;
              end
              OPC_WRITE: if (wel_q) begin
                state_d = ST_ADDR;
                iswr_d  = 1'b1;
                wrf_d   = 1'b1;
              end
              OPC_RDID: if (ID_ENABLE) begin
                state_d = ST_ID;
                tx_d    = ID_MAKER;
                oe_d    = 1'b1;
                idx_d   = 2'd1;
              end
              default: state_d = ST_SKIP;
            endcase
          end
          ST_ADDR: begin
            ashift_d = addr_now;
            acnt_d   = acnt_q + 2'd1;
            if (acnt_q == 2'(ADDR_BYTES - 1)) begin
              if (iswr_q) begin
                state_d = ST_WDAT;
                ptr_d   = addr_now;
              end else begin
                state_d = ST_RDAT;
                tx_d    = rdata;
                ptr_d   = addr_now + AW'(1);
                oe_d    = 1'b1;
              end
            end
          end
          ST_RDAT: begin
            tx_d  = rdata;
            ptr_d = ptr_q + AW'(1);
          end
          ST_WDAT: begin
            mem_we = 1'b1;
            ptr_d  = ptr_q + AW'(1);
          end
          ST_SRD: tx_d = status_val;
          ST_SWR: begin
            sr_d    = byte_val & SR_WMASK;
            state_d = ST_SKIP;
          end
          ST_ID: begin
            unique case (idx_q)
              2'd1:    tx_d = FAMILY_ID;
              2'd2:    tx_d = SUB_ID;
              default: tx_d = 8'h00;
            endcase
            if (idx_q != 2'd3) idx_d = idx_q + 2'd1;
          end
          default: state_d = ST_SKIP;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      state_q  <= ST_OPC;
      acnt_q   <= 2'd0;
      idx_q    <= 2'd0;
      ashift_q <= '0;
      ptr_q    <= '0;
      wel_q    <= 1'b0;
      wrf_q    <= 1'b0;
      iswr_q   <= 1'b0;
      miso_q   <= 1'b0;
      oe_q     <= 1'b0;
      sr_q     <= 8'd0;
      tx_q     <= 8'd0;
    end else begin
      state_q  <= state_d;
      acnt_q   <= acnt_d;
      idx_q    <= idx_d;
      ashift_q <= ashift_d;
      ptr_q    <= ptr_d;
      wel_q    <= wel_d;
      wrf_q    <= wrf_d;
      iswr_q   <= iswr_d;
      miso_q   <= miso_d;
      oe_q     <= oe_d;
      sr_q     <= sr_d;
      tx_q     <= tx_d;
    end
  end

  assign miso    = miso_q;
  assign miso_oe = oe_q;
endmodule

// File: rtl/fram_target_chk.sv
module fram_target_chk #(
  parameter int DEPTH = 128,
  localparam int AW = $clog2(DEPTH)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs_s,
  input logic          fall,
  input logic          cs_end,
  input logic          miso,
  input logic          miso_oe,
  input logic          mem_we,
  input logic          wel,
  input logic          wrf,
  input logic [AW-1:0] ptr
);
  assert_oe_idle_R14: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> !miso_oe);

  assert_miso_on_fall_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(miso) |-> $past(fall));

  assert_write_needs_latch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> wel);

  assert_latch_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_end && wrf) |=> !wel);

  assert_addr_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && ptr == AW'(DEPTH - 1)) |=> (ptr == '0));
endmodule

bind fram_spi_target fram_target_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_core_n), .cs_s(cs_s), .fall(fall), .cs_end(cs_end),
  .miso(miso_q), .miso_oe(oe_q), .mem_we(mem_we), .wel(wel_q),
  .wrf(wrf_q), .ptr(ptr_q)
);

// File: tb/test_fram_spi_target.sv
module test_fram_spi_target;
  localparam int HALF = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0;
  logic mosi = 1'b0;
  logic cs_a = 1'b1;
  logic cs_b = 1'b1;
  logic sel = 1'b0;
  logic miso_a, oe_a, miso_b, oe_b;
  logic oe_seen, timing_bad;
  logic [7:0] rbuf [8];
  logic [7:0] wbuf [8];
  int n_cmp = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  fram_spi_target #(.ADDR_BYTES(2), .DEPTH(128), .ID_ENABLE(1'b1),
                    .FAMILY_ID(8'h22), .SUB_ID(8'h01)) i_fram_spi_target (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_a), .mosi(mosi),
    .miso(miso_a), .miso_oe(oe_a));

  fram_spi_target #(.ADDR_BYTES(3), .DEPTH(128), .ID_ENABLE(1'b0)) i_fram_spi_target_b (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_b), .mosi(mosi),
    .miso(miso_b), .miso_oe(oe_b));

  wire cur_miso = sel ? miso_b : miso_a;
  wire cur_oe   = sel ? oe_b : oe_a;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic frame_begin();
    @(negedge clk);
    if (sel) cs_b = 1'b0; else cs_a = 1'b0;
    repeat (6) @(negedge clk);
    oe_seen = 1'b0;
  endtask

  task automatic frame_end();
    repeat (HALF) @(negedge clk);
    cs_a = 1'b1;
    cs_b = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      @(negedge clk);
      mosi = tx[i];
      repeat (HALF - 1) @(negedge clk);
      rx[i] = cur_miso;
      if (cur_oe) oe_seen = 1'b1;
      sclk = 1'b1;
      repeat (HALF - 1) @(negedge clk);
      if (cur_oe && cur_miso !== rx[i]) timing_bad = 1'b1;
      @(negedge clk);
      sclk = 1'b0;
    end
  endtask

  task automatic cmd1(input logic [7:0] op);
    logic [7:0] d;
    frame_begin(); xfer(op, d); frame_end();
  endtask

  task automatic rdsr(input int n);
    logic [7:0] d;
    frame_begin(); xfer(8'h05, d);
    for (int k = 0; k < n; k++) begin xfer(8'h00, d); rbuf[k] = d; end
    frame_end();
  endtask

  task automatic send_addr(input logic [23:0] a);
    logic [7:0] d;
    if (sel) xfer(a[23:16], d);
    xfer(a[15:8], d);
    xfer(a[7:0], d);
  endtask

  task automatic mem_read(input logic [23:0] a, input int n);
    logic [7:0] d;
    frame_begin(); xfer(8'h03, d); send_addr(a);
    for (int k = 0; k < n; k++) begin xfer(8'h00, d); rbuf[k] = d; end
    frame_end();
  endtask

  task automatic mem_write(input logic [23:0] a, input int n);
    logic [7:0] d;
    frame_begin(); xfer(8'h02, d); send_addr(a);
    for (int k = 0; k < n; k++) xfer(wbuf[k], d);
    frame_end();
  endtask

  task automatic t_reset();
    check("R1 oe after reset", {7'd0, oe_a}, 8'h00);
    rdsr(1);
    check("R1 status after reset", rbuf[0], 8'h00);
    check("R14 oe after frame", {7'd0, oe_a}, 8'h00);
  endtask

  task automatic t_latch();
    cmd1(8'h06);
    rdsr(2);
    check("R2 latch set", rbuf[0], 8'h02);
    check("R3 status repeats", rbuf[1], 8'h02);
    cmd1(8'h04);
    rdsr(1);
    check("R2 latch cleared", rbuf[0], 8'h00);
  endtask

  task automatic t_status_write();
    logic [7:0] d;
    cmd1(8'h06);
    frame_begin(); xfer(8'h01, d); xfer(8'hFF, d); frame_end();
    rdsr(1);
    check("R4 R3 R8 status write", rbuf[0], 8'hCC);
    frame_begin(); xfer(8'h01, d); xfer(8'h00, d); frame_end();
    rdsr(1);
    check("R4 write without latch", rbuf[0], 8'hCC);
    cmd1(8'h06);
    frame_begin(); xfer(8'h01, d); xfer(8'h00, d); frame_end();
    rdsr(1);
    check("R4 status cleared", rbuf[0], 8'h00);
  endtask

  task automatic t_write_read();
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33; wbuf[3] = 8'h44;
    cmd1(8'h06);
    mem_write(24'h000010, 4);
    rdsr(1);
    check("R8 latch clear after write", rbuf[0], 8'h00);
    mem_read(24'h000010, 4);
    check("R5 R6 byte 0", rbuf[0], 8'h11);
    check("R6 byte 1", rbuf[1], 8'h22);
    check("R6 byte 2", rbuf[2], 8'h33);
    check("R6 byte 3", rbuf[3], 8'h44);
    mem_read(24'h000012, 2);
    check("R5 mid start", rbuf[0], 8'h33);
    check("R5 mid next", rbuf[1], 8'h44);
    check("R13 miso stable over rise", {7'd0, timing_bad}, 8'h00);
  endtask

  task automatic t_nolatch();
    wbuf[0] = 8'h99;
    mem_write(24'h000010, 1);
    mem_read(24'h000010, 1);
    check("R7 write ignored", rbuf[0], 8'h11);
  endtask

  task automatic t_wrap();
    wbuf[0] = 8'hAA; wbuf[1] = 8'hBB;
    cmd1(8'h06);
    mem_write(24'h00007F, 2);
    mem_read(24'h00007F, 2);
    check("R9 last byte", rbuf[0], 8'hAA);
    check("R9 wrapped read", rbuf[1], 8'hBB);
    mem_read(24'h000080, 1);
    check("R9 high bits ignored", rbuf[0], 8'hBB);
  endtask

  task automatic t_id();
    logic [7:0] d;
    frame_begin(); xfer(8'h9F, d);
    xfer(8'h00, d); check("R10 maker", d, 8'hC2);
    xfer(8'h00, d); check("R10 family", d, 8'h22);
    xfer(8'h00, d); check("R10 sub", d, 8'h01);
    frame_end();
    check("R14 oe low after id", {7'd0, oe_a}, 8'h00);
  endtask

  task automatic t_noid();
    logic [7:0] d;
    sel = 1'b1;
    frame_begin(); xfer(8'h9F, d);
    for (int k = 0; k < 3; k++) xfer(8'h00, d);
    frame_end();
    check("R11 oe stays low", {7'd0, oe_seen}, 8'h00);
    sel = 1'b0;
  endtask

  task automatic t_addr3();
    sel = 1'b1;
    wbuf[0] = 8'h5A; wbuf[1] = 8'hA5;
    cmd1(8'h06);
    mem_write(24'h000005, 2);
    mem_read(24'h000005, 2);
    check("R5 three addr bytes 0", rbuf[0], 8'h5A);
    check("R5 three addr bytes 1", rbuf[1], 8'hA5);
    sel = 1'b0;
  endtask

  task automatic t_unknown();
    logic [7:0] d;
    cmd1(8'h06);
    frame_begin(); xfer(8'hAB, d); xfer(8'h02, d); xfer(8'h00, d); xfer(8'h10, d); xfer(8'h77, d);
    frame_end();
    check("R12 oe low", {7'd0, oe_seen}, 8'h00);
    rdsr(1);
    check("R12 latch kept", rbuf[0], 8'h02);
    mem_read(24'h000010, 1);
    check("R12 array kept", rbuf[0], 8'h11);
    cmd1(8'h04);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    oe_seen = 1'b0;
    timing_bad = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_latch();
    t_status_write();
    t_write_read();
    t_nolatch();
    t_wrap();
    t_id();
    t_noid();
    t_addr3();
    t_unknown();
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
    $finish;
  end
endmodule